// File: doc/BRIEF.md
# Switch Driver Load Diagnostics Filter

This block sits between a channel controller and the analog output stages of a set of power switches: a few high-side channels driving lamps or LEDs and a few low-side channels driving relays. For each channel it gates the final drive signal from an on command and a PWM input. It also turns raw overload and underload comparator outputs into sticky diagnostic flags, using filter windows measured in ticks of a 1 µs time base. A channel whose overload persists is latched off.

Two supply comparators report undervoltage and overvoltage on the driver supply rail. They set sticky flags. A policy bit decides whether an active supply fault also forces every gate off. Software clears any flag through a write strobe and a per-flag clear mask. A pending detection always wins over a clear that lands in the same cycle.

Top module: `swdrv_diag_top`

## Requirements
- R1: Each gate output is registered. One cycle after its inputs are sampled, it equals on command AND PWM input, unless the channel is latched off or forced off. All gates and flags are 0 after reset.
- R2: On every rising edge of a high-side gate, including each rising edge caused by PWM, the channel's underload comparator is ignored for the next BLANK_TICKS ticks (default 80).
- R3: After blanking, the high-side underload flag is set on the UL_TICKS-th tick (default 60) on which the comparator is high and the gate is high. With the comparator held high from a fresh turn-on, the flag appears 141 clock edges after the command when a tick is present every cycle.
- R4: On any channel, high-side or low-side, the overload flag is set on the OL_TICKS-th tick (default 60) of a continuous overload indication. The gate turns off in that same clock edge. Cycles without a tick do not advance the count.
- R5: When a comparator input deasserts before its filter completes, the filter count returns to zero. The full window is then needed again.
- R6: A channel latched off by overload stays off until its overload flag has been cleared and its on command has been seen low and then high again.
- R7: The undervoltage and overvoltage flags set one cycle after their comparator is high. They stay set until cleared. A clear while the comparator is still high leaves the flag set.
- R8: When the policy input is 1, an active undervoltage or overvoltage comparator forces all gates to 0 one cycle later. When it is 0, the gates are unaffected.
- R9: A clear write (clr_wr=1) clears exactly the flags whose mask bits are 1. The mask layout is: bits 0..NUM_HS-1 for high-side overload, the next NUM_HS bits for high-side underload, the next NUM_LS bits for low-side overload, then one bit for undervoltage and one bit for overvoltage. With the defaults, bit 6 is low-side overload channel 0, bit 8 is undervoltage and bit 9 is overvoltage.
- R10: A flag whose detection fires in the same cycle as its clear ends that cycle set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle time base pulse, one per microsecond |
| hs_on | input | NUM_HS | High-side on commands |
| hs_pwm | input | NUM_HS | High-side PWM gating inputs |
| hs_ol_cmp | input | NUM_HS | High-side overload comparators |
| hs_ul_cmp | input | NUM_HS | High-side underload comparators |
| ls_on | input | NUM_LS | Low-side on commands |
| ls_pwm | input | NUM_LS | Low-side PWM gating inputs |
| ls_ol_cmp | input | NUM_LS | Low-side overload comparators |
| sup_uv_cmp | input | 1 | Driver supply undervoltage comparator |
| sup_ov_cmp | input | 1 | Driver supply overvoltage comparator |
| uvov_off_en | input | 1 | Policy: supply fault forces gates off |
| clr_wr | input | 1 | Flag clear write strobe |
| clr_mask | input | 2*NUM_HS+NUM_LS+2 | Per-flag clear mask (layout in R9) |
| hs_gate | output | NUM_HS | High-side final gate enables |
| ls_gate | output | NUM_LS | Low-side final gate enables |
| hs_ol_flag | output | NUM_HS | High-side sticky overload flags |
| hs_ul_flag | output | NUM_HS | High-side sticky underload flags |
| ls_ol_flag | output | NUM_LS | Low-side sticky overload flags |
| uv_flag | output | 1 | Sticky supply undervoltage flag |
| ov_flag | output | 1 | Sticky supply overvoltage flag |

## Verification
The overload filter completing and a software clear of the same flag can fall in the same cycle. The bench holds a low-side overload for 59 ticks and raises the clear strobe for that flag so that it is sampled in the same edge as the 60th tick. It then expects the flag to remain set and the gate to be off. A second collision is provoked by clearing the undervoltage flag while its comparator is still high; the flag must survive and the untouched overvoltage flag must keep its value.

// File: rtl/swdrv_diag_pkg.sv
package swdrv_diag_pkg;

    // Registered per-channel control and diagnostic bits
    typedef struct packed {
        logic gate;
        logic trip;
        logic ol_flag;
        logic ul_flag;
    } chan_bits_t;

    // Supply fault flags
    typedef struct packed {
        logic uv;
        logic ov;
    } sup_bits_t;

endpackage

// File: rtl/swdrv_persist_filter.sv
// Persistence filter: fires on the LEN-th qualifying tick of a continuous condition.
module swdrv_persist_filter #(
    parameter int unsigned LEN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic cond_i,
    input  logic en_i,
    output logic fire_o
);
    localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } flt_st_t;

    flt_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        if (!cond_i) begin
            st_d.cnt = '0;
        end else if (tick_i && en_i) begin
            if (st_q.cnt == LAST) begin
                fire_o = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: count never exceeds the window and restarts when the condition drops
    p_cnt_range_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    p_restart_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        !cond_i |=> (st_q.cnt == '0));

endmodule

// File: rtl/swdrv_chan.sv
// One switch channel: gating, overload latch-off, optional blanking and underload filter.
module swdrv_chan
    import swdrv_diag_pkg::*;
#(
    parameter bit          HAS_UL      = 1'b1,
    parameter int unsigned BLANK_TICKS = 80,
    parameter int unsigned UL_TICKS    = 60,
    parameter int unsigned OL_TICKS    = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic force_off_i,
    input  logic on_i,
    input  logic pwm_i,
    input  logic ol_cmp_i,
    input  logic ul_cmp_i,
    input  logic clr_ol_i,
    input  logic clr_ul_i,
    output logic gate_o,
    output logic ol_flag_o,
    output logic ul_flag_o
);
    localparam int unsigned BW = $clog2(BLANK_TICKS + 1);
    localparam logic [BW-1:0] BLANK_LD = BW'(BLANK_TICKS);

    typedef struct packed {
        chan_bits_t    f;
        logic [BW-1:0] blank;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic ol_fire;
    logic ul_fire;
    logic ul_en;
    logic gate_nx;

    assign ul_en = st_q.f.gate && (st_q.blank == '0);

    swdrv_persist_filter #(.LEN(OL_TICKS)) u_ol_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .cond_i (ol_cmp_i),
        .en_i   (1'b1),
        .fire_o (ol_fire)
    );

    generate
        if (HAS_UL) begin : g_ul
            swdrv_persist_filter #(.LEN(UL_TICKS)) u_ul_flt (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick_i (tick_i),
                .cond_i (ul_cmp_i),
                .en_i   (ul_en),
                .fire_o (ul_fire)
            );

            // R2: an underload flag only rises from a count taken outside blanking
            p_ul_after_blank_r2 : assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_q.f.ul_flag) |-> $past(st_q.f.gate && (st_q.blank == '0)));
        end else begin : g_no_ul
            logic unused_ul;
            assign unused_ul = ul_cmp_i ^ ul_en ^ clr_ul_i;
            assign ul_fire   = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d    = st_q;
        gate_nx = on_i && pwm_i && !st_q.f.trip && !ol_fire && !force_off_i;
        st_d.f.gate    = gate_nx;
        st_d.f.ol_flag = ol_fire || (st_q.f.ol_flag && !clr_ol_i);
        st_d.f.ul_flag = ul_fire || (st_q.f.ul_flag && !clr_ul_i);

        if (ol_fire) begin
            st_d.f.trip = 1'b1;
        end else if (!st_d.f.ol_flag && !on_i) begin
            st_d.f.trip = 1'b0;
        end

        if (gate_nx && !st_q.f.gate) begin
            st_d.blank = BLANK_LD;
        end else if (tick_i && (st_q.blank != '0)) begin
            st_d.blank = st_q.blank - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_o    = st_q.f.gate;
    assign ol_flag_o = st_q.f.ol_flag;
    assign ul_flag_o = st_q.f.ul_flag;

    // R4: the overload flag rises together with the gate turning off
    p_ol_gate_off_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.f.ol_flag) |-> !st_q.f.gate);
    // R6: a latched channel produces no gate in the following cycle
    p_trip_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        st_q.f.trip |=> !st_q.f.gate);

endmodule

// File: rtl/swdrv_diag_top.sv
module swdrv_diag_top
    import swdrv_diag_pkg::*;
#(
    parameter int unsigned NUM_HS      = 3,
    parameter int unsigned NUM_LS      = 2,
    parameter int unsigned BLANK_TICKS = 80,
    parameter int unsigned UL_TICKS    = 60,
    parameter int unsigned OL_TICKS    = 60
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_1us,
    input  logic [NUM_HS-1:0]          hs_on,
    input  logic [NUM_HS-1:0]          hs_pwm,
    input  logic [NUM_HS-1:0]          hs_ol_cmp,
    input  logic [NUM_HS-1:0]          hs_ul_cmp,
    input  logic [NUM_LS-1:0]          ls_on,
    input  logic [NUM_LS-1:0]          ls_pwm,
    input  logic [NUM_LS-1:0]          ls_ol_cmp,
    input  logic                       sup_uv_cmp,
    input  logic                       sup_ov_cmp,
    input  logic                       uvov_off_en,
    input  logic                       clr_wr,
    input  logic [2*NUM_HS+NUM_LS+1:0] clr_mask,
    output logic [NUM_HS-1:0]          hs_gate,
    output logic [NUM_LS-1:0]          ls_gate,
    output logic [NUM_HS-1:0]          hs_ol_flag,
    output logic [NUM_HS-1:0]          hs_ul_flag,
    output logic [NUM_LS-1:0]          ls_ol_flag,
    output logic                       uv_flag,
    output logic                       ov_flag
);
    localparam int unsigned IDX_HS_OL = 0;
    localparam int unsigned IDX_HS_UL = NUM_HS;
    localparam int unsigned IDX_LS_OL = 2 * NUM_HS;
    localparam int unsigned IDX_UV    = 2 * NUM_HS + NUM_LS;
    localparam int unsigned IDX_OV    = IDX_UV + 1;

    sup_bits_t sup_d, sup_q;
    logic force_off;
    logic [NUM_LS-1:0] unused_ls_ul;

    assign force_off = uvov_off_en && (sup_uv_cmp || sup_ov_cmp);

    generate
        for (genvar i = 0; i < NUM_HS; i++) begin : g_hs
            swdrv_chan #(
                .HAS_UL      (1'b1),
                .BLANK_TICKS (BLANK_TICKS),
                .UL_TICKS    (UL_TICKS),
                .OL_TICKS    (OL_TICKS)
            ) u_chan (
                .clk         (clk),
                .rst_n       (rst_n),
                .tick_i      (tick_1us),
                .force_off_i (force_off),
                .on_i        (hs_on[i]),
                .pwm_i       (hs_pwm[i]),
                .ol_cmp_i    (hs_ol_cmp[i]),
                .ul_cmp_i    (hs_ul_cmp[i]),
                .clr_ol_i    (clr_wr && clr_mask[IDX_HS_OL + i]),
                .clr_ul_i    (clr_wr && clr_mask[IDX_HS_UL + i]),
                .gate_o      (hs_gate[i]),
                .ol_flag_o   (hs_ol_flag[i]),
                .ul_flag_o   (hs_ul_flag[i])
            );
        end
        for (genvar j = 0; j < NUM_LS; j++) begin : g_ls
            swdrv_chan #(
                .HAS_UL      (1'b0),
                .BLANK_TICKS (BLANK_TICKS),
                .UL_TICKS    (UL_TICKS),
                .OL_TICKS    (OL_TICKS)
            ) u_chan (
                .clk         (clk),
                .rst_n       (rst_n),
                .tick_i      (tick_1us),
                .force_off_i (force_off),
                .on_i        (ls_on[j]),
                .pwm_i       (ls_pwm[j]),
                .ol_cmp_i    (ls_ol_cmp[j]),
                .ul_cmp_i    (1'b0),
                .clr_ol_i    (clr_wr && clr_mask[IDX_LS_OL + j]),
                .clr_ul_i    (1'b0),
                .gate_o      (ls_gate[j]),
                .ol_flag_o   (ls_ol_flag[j]),
                .ul_flag_o   (unused_ls_ul[j])
            );
        end
    endgenerate

    always_comb begin
        sup_d    = sup_q;
        sup_d.uv = sup_uv_cmp || (sup_q.uv && !(clr_wr && clr_mask[IDX_UV]));
        sup_d.ov = sup_ov_cmp || (sup_q.ov && !(clr_wr && clr_mask[IDX_OV]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sup_q <= '0;
        else        sup_q <= sup_d;
    end

    assign uv_flag = sup_q.uv;
    assign ov_flag = sup_q.ov;

    // R1: a gate is only on when its command and PWM were both high the cycle before
    p_gate_cmd_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        ((hs_gate & ~$past(hs_on & hs_pwm)) == '0) && ((ls_gate & ~$past(ls_on & ls_pwm)) == '0));
    // R8: an enforced supply fault removes every gate one cycle later
    p_force_gates_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (uvov_off_en && (sup_uv_cmp || sup_ov_cmp)) |=> ((hs_gate == '0) && (ls_gate == '0)));
    // R7: supply flags persist without a matching clear
    p_uv_sticky_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (uv_flag && !(clr_wr && clr_mask[IDX_UV])) |=> uv_flag);
    p_ov_sticky_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (ov_flag && !(clr_wr && clr_mask[IDX_OV])) |=> ov_flag);

endmodule

// File: tb/swdrv_diag_top_tb.sv
module swdrv_diag_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1us = 1'b0;
    logic [2:0] hs_on = '0, hs_pwm = '0, hs_ol_cmp = '0, hs_ul_cmp = '0;
    logic [1:0] ls_on = '0, ls_pwm = '0, ls_ol_cmp = '0;
    logic       sup_uv_cmp = 1'b0, sup_ov_cmp = 1'b0, uvov_off_en = 1'b0;
    logic       clr_wr = 1'b0;
    logic [9:0] clr_mask = '0;
    logic [2:0] hs_gate, hs_ol_flag, hs_ul_flag;
    logic [1:0] ls_gate, ls_ol_flag;
    logic       uv_flag, ov_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2ns clk = ~clk;

    swdrv_diag_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us),
        .hs_on(hs_on), .hs_pwm(hs_pwm), .hs_ol_cmp(hs_ol_cmp), .hs_ul_cmp(hs_ul_cmp),
        .ls_on(ls_on), .ls_pwm(ls_pwm), .ls_ol_cmp(ls_ol_cmp),
        .sup_uv_cmp(sup_uv_cmp), .sup_ov_cmp(sup_ov_cmp), .uvov_off_en(uvov_off_en),
        .clr_wr(clr_wr), .clr_mask(clr_mask),
        .hs_gate(hs_gate), .ls_gate(ls_gate), .hs_ol_flag(hs_ol_flag),
        .hs_ul_flag(hs_ul_flag), .ls_ol_flag(ls_ol_flag),
        .uv_flag(uv_flag), .ov_flag(ov_flag)
    );

    // {on, pwm, uv, ov, policy, expected gate}
    localparam logic [5:0] VEC [8] = '{
        6'b110001, 6'b100000, 6'b010000, 6'b111001,
        6'b111010, 6'b110110, 6'b110101, 6'b110011
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_flags(input logic [9:0] m);
        clr_wr = 1'b1; clr_mask = m;
        cyc(1);
        clr_wr = 1'b0; clr_mask = '0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check("R1 reset gates", {hs_gate, ls_gate}, 0);
        check("R7 reset flags", {hs_ol_flag, hs_ul_flag, ls_ol_flag, uv_flag, ov_flag}, 0);

        // Vector table: gate combination and supply policy (R1, R8), no ticks
        for (int k = 0; k < 8; k++) begin
            hs_on = {3{VEC[k][5]}}; ls_on = {2{VEC[k][5]}};
            hs_pwm = {3{VEC[k][4]}}; ls_pwm = {2{VEC[k][4]}};
            sup_uv_cmp = VEC[k][3]; sup_ov_cmp = VEC[k][2]; uvov_off_en = VEC[k][1];
            cyc(1);
            check("R1/R8 vector hs gate", hs_gate, {3{VEC[k][0]}});
            check("R1/R8 vector ls gate", ls_gate, {2{VEC[k][0]}});
        end
        hs_on = '0; ls_on = '0; sup_uv_cmp = 0; sup_ov_cmp = 0; uvov_off_en = 0;
        hs_pwm = 3'b111; ls_pwm = 2'b11;
        clear_flags(10'h3FF);
        check("R9 clear all", {uv_flag, ov_flag}, 0);

        // R3 underload after blanking, continuous tick
        tick_1us = 1'b1;
        hs_on[0] = 1'b1; hs_ul_cmp[0] = 1'b1;
        cyc(140);
        check("R3 ul not yet", hs_ul_flag, 0);
        cyc(1);
        check("R3 ul set", hs_ul_flag, 3'b001);
        hs_ul_cmp[0] = 1'b0;

        // R2 blanking restarts on a PWM rising edge
        hs_on[1] = 1'b1; hs_ul_cmp[1] = 1'b1;
        cyc(50);
        hs_pwm[1] = 1'b0;
        cyc(1);
        hs_pwm[1] = 1'b1;
        cyc(140);
        check("R2 ul held by restarted blank", hs_ul_flag[1], 0);
        cyc(1);
        check("R2 ul after restarted blank", hs_ul_flag[1], 1);
        hs_ul_cmp[1] = 1'b0;

        // R5 overload filter restart, R4 latch-off on hs2
        hs_on[2] = 1'b1;
        cyc(2);
        hs_ol_cmp[2] = 1'b1;
        cyc(40);
        hs_ol_cmp[2] = 1'b0;
        cyc(1);
        hs_ol_cmp[2] = 1'b1;
        cyc(59);
        check("R5 ol count restarted", hs_ol_flag[2], 0);
        check("R5 gate still on", hs_gate[2], 1);
        cyc(1);
        check("R4 ol flag set", hs_ol_flag[2], 1);
        check("R4 gate latched off", hs_gate[2], 0);
        hs_ol_cmp[2] = 1'b0;

        // R6 re-arm needs clear plus a fresh on command
        clear_flags(10'b0000000100);
        check("R9 hs2 ol cleared only", {hs_ol_flag, hs_ul_flag}, 6'b000011);
        cyc(2);
        check("R6 stays off with on held", hs_gate[2], 0);
        hs_on[2] = 1'b0;
        cyc(1);
        hs_on[2] = 1'b1;
        cyc(1);
        check("R6 re-armed", hs_gate[2], 1);

        // R4 low-side overload
        ls_on = 2'b10;
        cyc(2);
        ls_ol_cmp[1] = 1'b1;
        cyc(59);
        check("R4 ls ol not yet", ls_ol_flag, 0);
        cyc(1);
        check("R4 ls ol set", ls_ol_flag, 2'b10);
        check("R4 ls gate off", ls_gate[1], 0);
        ls_ol_cmp[1] = 1'b0;

        // R10 detection and clear in the same edge
        ls_on = 2'b11;
        ls_ol_cmp[0] = 1'b1;
        cyc(59);
        clr_wr = 1'b1; clr_mask = 10'b0001000000;
        cyc(1);
        clr_wr = 1'b0; clr_mask = '0;
        check("R10 set wins over clear", ls_ol_flag[0], 1);
        check("R10 ls gate off", ls_gate[0], 0);
        ls_ol_cmp[0] = 1'b0;

        // R8 supply policy
        hs_on = 3'b111;
        cyc(2);
        check("R1 all hs on", hs_gate, 3'b111);
        sup_uv_cmp = 1'b1;
        cyc(1);
        check("R7 uv flag set", uv_flag, 1);
        check("R8 policy off keeps gates", hs_gate, 3'b111);
        uvov_off_en = 1'b1;
        cyc(1);
        check("R8 uv forces off", {hs_gate, ls_gate}, 0);
        sup_uv_cmp = 1'b0;
        cyc(1);
        check("R8 gates back", hs_gate, 3'b111);
        sup_ov_cmp = 1'b1;
        cyc(1);
        check("R7 ov flag set", ov_flag, 1);
        check("R8 ov forces off", hs_gate, 0);
        sup_ov_cmp = 1'b0; uvov_off_en = 1'b0;
        cyc(1);

        // R7 clear while comparator active, R9 selective clear
        sup_uv_cmp = 1'b1;
        clear_flags(10'b0100000000);
        check("R7 uv survives clear", uv_flag, 1);
        check("R9 ov untouched", ov_flag, 1);
        sup_uv_cmp = 1'b0;
        clear_flags(10'b0100000000);
        check("R7 uv cleared", uv_flag, 0);
        check("R9 ov still set", ov_flag, 1);
        clear_flags(10'b1000000000);
        check("R7 ov cleared", ov_flag, 0);

        // R4 only ticks advance the overload filter
        tick_1us = 1'b0;
        hs_ol_cmp[0] = 1'b1;
        cyc(100);
        check("R4 no tick no count", hs_ol_flag[0], 0);
        check("R4 gate on without ticks", hs_gate[0], 1);
        tick_1us = 1'b1;
        cyc(60);
        check("R4 ol after ticks", hs_ol_flag[0], 1);
        check("R4 gate off after ticks", hs_gate[0], 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule